// File: doc/BRIEF.md
# Conditional Block Slot Tracker

This block keeps the state of a short run of predicated instructions opened by a single "if-then" style instruction. That instruction supplies a base condition code, a block length of one to four slots and, for each slot after the first, a then or else choice. The block then tells the execute stage whether each instruction that reaches it should take effect or be squashed. A then slot passes when the base condition holds against the current N, Z, C and V flags. An else slot passes when the inverse holds. Outside a block every instruction passes.

The whole state sits in one packed field. The upper bits give the condition that applies to the current slot. The lower bits are a mask that shifts once per retired instruction, and a trailing one in that mask marks where the block ends. Exception logic reads this field for saving. It writes the field back on return, or writes zero on entry, so that a block interrupted partway through resumes with exactly the slots it had left.

A load that arrives while a block is still open is refused and flagged. So is a load whose condition cannot be used as requested.

Top module: `itb_tracker`

## Requirements
- R1: After synchronous reset the state field is 0, in_block_o is 0, load_err_o is 0 and cond_pass_o is 1.
- R2: A load accepted outside a block writes the state as follows. Bits [7:4] take the base condition. Bit 4 together with bits [3:0] hold the condition LSB followed by the slot mask. Extra slot k (k = 1..len) occupies mask bit 4-k and holds the condition LSB XOR its else bit (ld_else_i bit k-1). The trailing one sits at bit 3-len. in_block_o is 1 from the next cycle.
- R3: While in a block, cond_pass_o reflects state bits [7:4] evaluated against flags_i = {N,Z,C,V}. Bits [3:1] select the test: 000 Z, 001 C, 010 N, 011 V, 100 C and not Z, 101 N equals V, 110 not Z and N equals V, 111 true. Bit 0 inverts the result, except for code 1111.
- R4: While not in a block, cond_pass_o is 1 whatever the flags.
- R5: Each advance_i pulse inside a block shifts state bits [4:0] left by one, which moves on to the next slot's condition. When bits [2:0] are already zero, the advance clears the whole field instead. A block loaded with length len therefore ends after len+1 advances.
- R6: A load while in_block_o is 1 leaves the state as it is, apart from any advance in the same cycle, and raises load_err_o for one cycle.
- R7: A load of code 1111, or of code 1110 with an else bit set within the block length, is ignored and raises load_err_o for one cycle.
- R8: restore_i overrides load and advance and writes restore_state_i into the state field. Writing zero closes the block. Writing a saved value resumes the remaining slots.
- R9: advance_i outside a block leaves the state field at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Open a new block |
| ld_cond_i | input | 4 | Base condition code |
| ld_len_i | input | 2 | Extra slots after the first (0..3) |
| ld_else_i | input | 3 | Bit k-1 set: extra slot k is an else slot |
| advance_i | input | 1 | Instruction in execute retires |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| restore_i | input | 1 | Write restore_state_i into the state |
| restore_state_i | input | 8 | State value to restore |
| cond_pass_o | output | 1 | Current instruction should take effect |
| in_block_o | output | 1 | A conditional block is open |
| state_o | output | 8 | Packed state field for saving |
| load_err_o | output | 1 | One-cycle pulse after a refused load |

## Verification
The condition evaluator is tried against a table of fifteen codes. For each code the table applies flag patterns that make the code pass and patterns that make it fail, so that a swapped flag or a lost inversion shows up. Two blocks with different lengths and mixed then/else slots are stepped slot by slot. The packed field and the pass output are compared at every step, which separates mask shifting from termination. Refused loads, a mid-block save and restore, idle advances and reset inside a block check that the state is only ever disturbed by the intended path.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int COND_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [2:0] {
    BT_ZERO   = 3'd0,
    BT_CARRY  = 3'd1,
    BT_NEG    = 3'd2,
    BT_OVF    = 3'd3,
    BT_HIGHER = 3'd4,
    BT_GE     = 3'd5,
    BT_GT     = 3'd6,
    BT_ALWAYS = 3'd7
  } base_test_e;
endpackage

// File: rtl/itb_cond_eval.sv
module itb_cond_eval
  import itb_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [3:0]        flags_i,
  output logic              pass_o
);
  logic raw;
  base_test_e test;

  assign test = base_test_e'(cond_i[3:1]);

  always_comb begin
    unique case (test)
      BT_ZERO:   raw = flags_i[FLAG_Z];
      BT_CARRY:  raw = flags_i[FLAG_C];
      BT_NEG:    raw = flags_i[FLAG_N];
      BT_OVF:    raw = flags_i[FLAG_V];
      BT_HIGHER: raw = flags_i[FLAG_C] & ~flags_i[FLAG_Z];
      BT_GE:     raw = flags_i[FLAG_N] == flags_i[FLAG_V];
      BT_GT:     raw = ~flags_i[FLAG_Z] & (flags_i[FLAG_N] == flags_i[FLAG_V]);
      default:   raw = 1'b1;
    endcase
  end

  // code 1111 has no inverse; treat as always
  assign pass_o = (test == BT_ALWAYS) ? 1'b1 : (raw ^ cond_i[0]);
endmodule

// File: rtl/itb_state_reg.sv
module itb_state_reg
  import itb_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LEN_W = $clog2(MAX_SLOTS),
  localparam int ST_W  = COND_W + MAX_SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 load_i,
  input  logic [COND_W-1:0]    ld_cond_i,
  input  logic [LEN_W-1:0]     ld_len_i,
  input  logic [MAX_SLOTS-2:0] ld_else_i,
  input  logic                 advance_i,
  input  logic                 restore_i,
  input  logic [ST_W-1:0]      restore_state_i,
  output logic [ST_W-1:0]      state_o,
  output logic                 in_block_o,
  output logic                 load_err_o
);
  logic [ST_W-1:0]      state_q;
  logic [ST_W-1:0]      built_state;
  logic [ST_W-1:0]      adv_state;
  logic [MAX_SLOTS-1:0] mask;
  logic [MAX_SLOTS-2:0] else_used;
  logic                 in_blk;
  logic                 bad_load;
  logic                 err_q;

  assign in_blk = |state_q[MAX_SLOTS-1:0];

  // assemble slot mask with a trailing one after the last slot
  always_comb begin
    mask      = '0;
    else_used = '0;
    for (int j = 0; j < MAX_SLOTS - 1; j++) begin
      if (j < int'(ld_len_i)) begin
        mask[MAX_SLOTS-1-j] = ld_cond_i[0] ^ ld_else_i[j];
        else_used[j]        = ld_else_i[j];
      end
    end
    mask[MAX_SLOTS-1-int'(ld_len_i)] = 1'b1;
  end

  assign built_state = {ld_cond_i[COND_W-1:1], ld_cond_i[0], mask};
  assign bad_load    = (ld_cond_i == 4'b1111) ||
                       ((ld_cond_i == 4'b1110) && (|else_used));

  always_comb begin
    if (state_q[MAX_SLOTS-2:0] == '0)
      adv_state = '0;
    else
      adv_state = {state_q[ST_W-1:MAX_SLOTS+1], state_q[MAX_SLOTS-1:0], 1'b0};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (restore_i) begin
        state_q <= restore_state_i;
      end else begin
        if (in_blk && advance_i)
          state_q <= adv_state;
        if (load_i) begin
          if (in_blk || bad_load)
            err_q <= 1'b1;
          else
            state_q <= built_state;
        end
      end
    end
  end

  assign state_o    = state_q;
  assign in_block_o = in_blk;
  assign load_err_o = err_q;

  // R6: a load inside a block is refused and flagged
  a_r6_reject_nested: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_blk && load_i && !advance_i && !restore_i) |=> (err_q && $stable(state_q)));

  // R5: advancing past the last slot closes the block
  a_r5_block_ends: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_blk && advance_i && !restore_i && state_q[MAX_SLOTS-2:0] == '0) |=> !in_blk);

  // R9: idle advance keeps the field clear
  a_r9_idle_stays: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_blk && !load_i && !restore_i) |=> (state_q == '0));

  // R8: restore takes priority
  a_r8_restore_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    restore_i |=> (state_q == $past(restore_state_i) && !err_q));

  // R7: reserved code never opens a block
  a_r7_reserved_code: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_blk && load_i && !restore_i && ld_cond_i == 4'b1111) |=> (err_q && !in_blk));
endmodule

// File: rtl/itb_tracker.sv
module itb_tracker
  import itb_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  localparam int LEN_W = $clog2(MAX_SLOTS),
  localparam int ST_W  = COND_W + MAX_SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 load_i,
  input  logic [COND_W-1:0]    ld_cond_i,
  input  logic [LEN_W-1:0]     ld_len_i,
  input  logic [MAX_SLOTS-2:0] ld_else_i,
  input  logic                 advance_i,
  input  logic [3:0]           flags_i,
  input  logic                 restore_i,
  input  logic [ST_W-1:0]      restore_state_i,
  output logic                 cond_pass_o,
  output logic                 in_block_o,
  output logic [ST_W-1:0]      state_o,
  output logic                 load_err_o
);
  logic [ST_W-1:0] state;
  logic            in_blk;
  logic            eval_pass;

  itb_state_reg #(.MAX_SLOTS(MAX_SLOTS)) u_state (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .load_i          (load_i),
    .ld_cond_i       (ld_cond_i),
    .ld_len_i        (ld_len_i),
    .ld_else_i       (ld_else_i),
    .advance_i       (advance_i),
    .restore_i       (restore_i),
    .restore_state_i (restore_state_i),
    .state_o         (state),
    .in_block_o      (in_blk),
    .load_err_o      (load_err_o)
  );

  itb_cond_eval u_eval (
    .cond_i  (state[ST_W-1 -: COND_W]),
    .flags_i (flags_i),
    .pass_o  (eval_pass)
  );

  assign cond_pass_o = !in_blk || eval_pass;
  assign in_block_o  = in_blk;
  assign state_o     = state;

  // R4: outside a block nothing is squashed
  a_r4_idle_pass: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_block_o |-> cond_pass_o);

  // R2: an accepted load opens the block
  a_r2_load_opens: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_block_o && load_i && !restore_i && ld_cond_i[3:1] != 3'b111) |=> in_block_o);
endmodule

// File: tb/itb_tracker_tb_top.sv
module itb_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [3:0] ld_cond = '0;
  logic [1:0] ld_len = '0;
  logic [2:0] ld_else = '0;
  logic       advance = 1'b0;
  logic [3:0] flags = '0;
  logic       restore = 1'b0;
  logic [7:0] restore_state = '0;
  logic       cond_pass, in_block, load_err;
  logic [7:0] state;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  itb_tracker dut_i (
    .clk_i(clk), .rst_i(rst), .load_i(load), .ld_cond_i(ld_cond),
    .ld_len_i(ld_len), .ld_else_i(ld_else), .advance_i(advance),
    .flags_i(flags), .restore_i(restore), .restore_state_i(restore_state),
    .cond_pass_o(cond_pass), .in_block_o(in_block), .state_o(state),
    .load_err_o(load_err)
  );

  // entry: {cond[3:0], NZCV[3:0], expected pass}
  localparam logic [8:0] VEC [19] = '{
    {4'b0000, 4'b0100, 1'b1}, {4'b0000, 4'b0000, 1'b0},
    {4'b0001, 4'b0100, 1'b0}, {4'b0010, 4'b0010, 1'b1},
    {4'b0011, 4'b0010, 1'b0}, {4'b0100, 4'b1000, 1'b1},
    {4'b0101, 4'b1000, 1'b0}, {4'b0110, 4'b0001, 1'b1},
    {4'b0111, 4'b0000, 1'b1}, {4'b1000, 4'b0010, 1'b1},
    {4'b1000, 4'b0110, 1'b0}, {4'b1001, 4'b0110, 1'b1},
    {4'b1010, 4'b1001, 1'b1}, {4'b1010, 4'b1000, 1'b0},
    {4'b1011, 4'b1000, 1'b1}, {4'b1100, 4'b0000, 1'b1},
    {4'b1100, 4'b0100, 1'b0}, {4'b1101, 4'b0100, 1'b1},
    {4'b1110, 4'b0000, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs change 1 ns after the edge, outputs read 2 ns after
  task automatic tick;
    @(posedge clk);
    #1;
    load = 0; advance = 0; restore = 0;
  endtask

  task automatic settle;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0; settle();
    check("R1 state", state, 8'h00);
    check("R1 in_block", {7'd0, in_block}, 8'd0);
    check("R1 err", {7'd0, load_err}, 8'd0);
    check("R1 pass", {7'd0, cond_pass}, 8'd1);

    // table walk: one-slot blocks per condition code
    foreach (VEC[i]) begin
      load = 1; ld_cond = VEC[i][8:5]; ld_len = 0; ld_else = 0;
      tick();
      flags = VEC[i][4:1]; advance = 1; settle();
      check("R3 pass", {7'd0, cond_pass}, {7'd0, VEC[i][0]});
      tick(); settle();
      check("R5 one slot ends", {7'd0, in_block}, 8'd0);
    end

    // R2/R5: EQ, 4 slots T T E T
    load = 1; ld_cond = 4'b0000; ld_len = 3; ld_else = 3'b010;
    tick(); flags = 4'b0100; settle();
    check("R2 packed", state, 8'h05);
    check("R3 slot1", {7'd0, cond_pass}, 8'd1);
    advance = 1; tick(); settle();
    check("R5 slot2", state, 8'h0A);
    advance = 1; tick(); settle();
    check("R5 slot3", state, 8'h14);
    check("R3 else slot", {7'd0, cond_pass}, 8'd0);
    // R6: nested load refused
    load = 1; ld_cond = 4'b1100; ld_len = 0;
    tick(); settle();
    check("R6 err", {7'd0, load_err}, 8'd1);
    check("R6 state kept", state, 8'h14);
    // R8: exception entry clears, return resumes
    restore = 1; restore_state = 8'h00; load = 1; ld_cond = 4'b0001;
    tick(); settle();
    check("R8 cleared", state, 8'h00);
    check("R8 no err", {7'd0, load_err}, 8'd0);
    restore = 1; restore_state = 8'h14;
    tick(); settle();
    check("R8 resumed", state, 8'h14);
    advance = 1; tick(); settle();
    check("R8 slot4", state, 8'h08);
    check("R8 slot4 pass", {7'd0, cond_pass}, 8'd1);
    advance = 1; tick(); flags = 4'b0000; settle();
    check("R5 end", state, 8'h00);
    check("R4 idle pass", {7'd0, cond_pass}, 8'd1);
    advance = 1; tick(); settle();
    check("R9 idle advance", state, 8'h00);

    // GT, 3 slots T E T
    load = 1; ld_cond = 4'b1100; ld_len = 2; ld_else = 3'b001;
    tick(); settle();
    check("R2 packed GT", state, 8'hCA);
    advance = 1; tick(); settle();
    check("R5 LE slot", state, 8'hD4);
    advance = 1; tick(); settle();
    check("R5 GT slot", state, 8'hC8);
    advance = 1; tick(); settle();
    check("R5 GT end", {7'd0, in_block}, 8'd0);

    // R7: always code with else, and reserved code
    load = 1; ld_cond = 4'b1110; ld_len = 1; ld_else = 3'b001;
    tick(); settle();
    check("R7 AL else err", {7'd0, load_err}, 8'd1);
    check("R7 AL else ignored", state, 8'h00);
    load = 1; ld_cond = 4'b1111; ld_len = 0; ld_else = 0;
    tick(); settle();
    check("R7 1111 err", {7'd0, load_err}, 8'd1);
    check("R7 1111 ignored", state, 8'h00);
    load = 1; ld_cond = 4'b1110; ld_len = 1; ld_else = 3'b100;
    tick(); settle();
    check("R7 AL unused else ok", state, 8'hE4);
    check("R7 no err", {7'd0, load_err}, 8'd0);

    // R1: reset inside a block
    rst = 1; tick(); rst = 0; settle();
    check("R1 reset in block", state, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule